// File: doc/BRIEF.md
# Spare Overhead Bit Validation Filter

This block sits behind the superframe receiver of a line interface. Once per received superframe it is handed the spare overhead bits: one group that goes to a receive register called here the M4 register, and a second group, the M5/M6 bits, that goes to the M56 register. Each bit passes through its own persistence filter. A programmable mode decides when a new value counts as valid: every superframe, on any change, or only after two or three identical receptions in a row. A group whose delivered value is refreshed latches the new value and places an entry naming its register into a small interrupt queue. A host then pops that queue one entry per read.

The same queue also carries M56 entries for two error events. One is a near-end CRC mismatch, and the entry records it in a cleared near-end bit. The other is a far-end block error bit received at zero. Each error event has its own enable. Whatever the enables are set to, each event also appears as a one-cycle pulse so that on-chip error counters can count it. The configuration byte holds the enables and the mode, and it resets to 0x1E.

Top module: `ovh_spare_validator`

## Requirements
- R1: After reset `cfgQ` reads 0x1E, `rxM4` and `rxM56` are zero, `qValid` is low and `qOverflow` is low.
- R2: With the mode field (`cfgQ[4:3]`) at 00, every `sfStrobe` copies the received bits straight into `rxM4` and `rxM56` and queues one entry for each group, whether the bits changed or not.
- R3: With mode 01, a group latches its received bits and queues one entry on a strobe where any of its bits differs from the value it currently holds. On a strobe with no difference it queues nothing.
- R4: With mode 10, a bit's new value reaches its receive register only on the second of two consecutive strobes that carry the same value.
- R5: With mode 11, a bit's new value reaches its receive register only on the third of three consecutive strobes that carry the same value.
- R6: Each bit is filtered on its own. One bit of a group can be accepted while another bit of the same group is still building up its run of identical receptions.
- R7: With the CRC enable (`cfgQ[7]`) set, a strobe with `crcMismatch` high queues an M56 entry even when no bit changed. In that entry the near-end bit (`qData[M56_W+1]`) is 0, and it is 1 when there is no mismatch.
- R8: With the far-end enable (`cfgQ[5]`) set, a strobe with `febeIn` low queues an M56 entry. That entry carries the received far-end bit in `qData[M56_W]`.
- R9: With both enables clear, the error events queue nothing. `nearErr` still pulses high for one cycle after a strobe with `crcMismatch` high, and `farErr` does the same after a strobe with `febeIn` low.
- R10: `qRegId` is 0 for an M4 entry and 1 for an M56 entry. M4 entries hold the register value zero-extended in `qData`. When both groups queue on the same strobe, the M4 entry comes out first.
- R11: The queue holds 4 entries and `popReq` removes the head when `qValid` is high. An entry that finds no room is dropped, the older entries are kept, and `qOverflow` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 8 | Configuration write data |
| cfgQ | output | 8 | Configuration byte: [7] CRC enable, [5] far-end enable, [4:3] mode |
| sfStrobe | input | 1 | One-cycle pulse per received superframe |
| m4In | input | M4_W | Received M4 spare bits |
| m56In | input | M56_W | Received M5/M6 spare bits |
| crcMismatch | input | 1 | Local CRC differs from received CRC (valid with strobe) |
| febeIn | input | 1 | Received far-end block error bit (valid with strobe) |
| rxM4 | output | M4_W | Validated M4 receive register |
| rxM56 | output | M56_W | Validated M56 receive register |
| popReq | input | 1 | Host read of the queue head |
| qValid | output | 1 | Queue not empty |
| qRegId | output | 1 | Register identifier of the head entry |
| qData | output | M56_W+2 | Data of the head entry |
| qOverflow | output | 1 | Sticky queue overflow flag |
| nearErr | output | 1 | Near-end CRC error pulse for counters |
| farErr | output | 1 | Far-end error pulse for counters |

## Verification
The assertions assume that `sfStrobe` is a single-cycle pulse and that the bit vectors, `crcMismatch` and `febeIn` are steady in the cycle the strobe is high. They also assume that the mode does not change in the same cycle as a strobe. The bench holds every input constant from one falling edge to the next. It writes the configuration only on cycles without a strobe, and it resets the block before each directed section so that the filter history is known.

// File: rtl/ovh_spare_pkg.sv
package ovh_spare_pkg;

  // Push requests issued by the control towards the datapath queue
  typedef struct packed {
    logic pushM4;
    logic pushM56;
  } ctrlStrobe_t;

  localparam logic       ID_M4      = 1'b0;
  localparam logic       ID_M56     = 1'b1;
  localparam logic [7:0] CFG_RESET  = 8'h1E;
  localparam int         CFG_CRC_EN = 7;
  localparam int         CFG_FAR_EN = 5;
  localparam int         CFG_MODE_LO = 3;

endpackage

// File: rtl/ovh_group_filter.sv
module ovh_group_filter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sample,
  input  logic [1:0]   mode,
  input  logic [W-1:0] bitsIn,
  output logic [W-1:0] delivered,
  output logic [W-1:0] nextVal,
  output logic         changed
);

  logic [W-1:0]      cand;
  logic [W-1:0][1:0] runLen;
  logic [W-1:0][1:0] runNext;
  logic [1:0]        need;

  always_comb begin
    case (mode)
      2'b01:   need = 2'd1;
      2'b10:   need = 2'd2;
      default: need = 2'd3;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (bitsIn[i] != cand[i])   runNext[i] = 2'd1;
      else if (runLen[i] == 2'd3) runNext[i] = 2'd3;
      else                        runNext[i] = runLen[i] + 2'd1;

      if (mode == 2'b00)           nextVal[i] = bitsIn[i];
      else if (runNext[i] >= need) nextVal[i] = bitsIn[i];
      else                         nextVal[i] = delivered[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cand[i]      <= 1'b0;
        runLen[i]    <= 2'd0;
        delivered[i] <= 1'b0;
      end else if (sample) begin
        cand[i]      <= bitsIn[i];
        runLen[i]    <= runNext[i];
        delivered[i] <= nextVal[i];
      end
    end

    // a fresh value never gets through on its first reception in the persistent modes
    AST_NO_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
      (sample && mode[1] && (bitsIn[i] != cand[i])) |=> $stable(delivered[i])); // R4
  end

  assign changed = (mode == 2'b00) || (nextVal != delivered);

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rstN)
    (sample && mode == 2'b00) |=> (delivered == $past(bitsIn))); // R2

endmodule

// File: rtl/ovh_spare_ctrl.sv
module ovh_spare_ctrl
  import ovh_spare_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [7:0]  cfgWdata,
  output logic [7:0]  cfgQ,
  output logic [1:0]  mode,
  input  logic        sfStrobe,
  input  logic        m4Changed,
  input  logic        m56Changed,
  input  logic        crcMismatch,
  input  logic        febeIn,
  output ctrlStrobe_t strobes,
  output logic        nearErr,
  output logic        farErr
);

  logic crcEn;
  logic farEn;

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= CFG_RESET;
    else if (cfgWe) cfgQ <= cfgWdata;
  end

  assign crcEn = cfgQ[CFG_CRC_EN];
  assign farEn = cfgQ[CFG_FAR_EN];
  assign mode  = cfgQ[CFG_MODE_LO +: 2];

  always_comb begin
    strobes.pushM4  = sfStrobe && m4Changed;
    strobes.pushM56 = sfStrobe && (m56Changed || (crcEn && crcMismatch) || (farEn && !febeIn));
  end

  // error pulses stay alive for the counters whatever the enables say
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nearErr <= 1'b0;
      farErr  <= 1'b0;
    end else begin
      nearErr <= sfStrobe && crcMismatch;
      farErr  <= sfStrobe && !febeIn;
    end
  end

  AST_NEAR_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    nearErr |=> !nearErr || $past(sfStrobe)); // R9
  AST_FAR_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    farErr |=> !farErr || $past(sfStrobe)); // R9

endmodule

// File: rtl/ovh_spare_dp.sv
module ovh_spare_dp
  import ovh_spare_pkg::*;
#(
  parameter int M4_W  = 3,
  parameter int M56_W = 4,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfStrobe,
  input  logic [1:0]        mode,
  input  logic [M4_W-1:0]   m4In,
  input  logic [M56_W-1:0]  m56In,
  input  logic              crcMismatch,
  input  logic              febeIn,
  input  ctrlStrobe_t       strobes,
  input  logic              popReq,
  output logic [M4_W-1:0]   rxM4,
  output logic [M56_W-1:0]  rxM56,
  output logic              m4Changed,
  output logic              m56Changed,
  output logic              qValid,
  output logic              qRegId,
  output logic [M56_W+1:0]  qData,
  output logic              qOverflow
);

  localparam int DW = M56_W + 2;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [M4_W-1:0]  m4Next;
  logic [M56_W-1:0] m56Next;

  ovh_group_filter #(.W(M4_W)) u_m4 (
    .clk(clk), .rstN(rstN), .sample(sfStrobe), .mode(mode), .bitsIn(m4In),
    .delivered(rxM4), .nextVal(m4Next), .changed(m4Changed));

  ovh_group_filter #(.W(M56_W)) u_m56 (
    .clk(clk), .rstN(rstN), .sample(sfStrobe), .mode(mode), .bitsIn(m56In),
    .delivered(rxM56), .nextVal(m56Next), .changed(m56Changed));

  // interrupt queue
  logic [DEPTH-1:0]         idMem;
  logic [DEPTH-1:0][DW-1:0] dataMem;
  logic [AW-1:0]            wrPtr, rdPtr;
  logic [CW-1:0]            fill;
  logic                     popDo, acc0, acc1, dropped;
  logic                     firstValid, firstId, secondValid;
  logic [DW-1:0]            m4Entry, m56Entry, firstData;
  int                       room;

  always_comb begin
    m4Entry     = DW'(m4Next);
    m56Entry    = {~crcMismatch, febeIn, m56Next};
    popDo       = popReq && (fill != '0);
    firstValid  = strobes.pushM4 || strobes.pushM56;
    firstId     = strobes.pushM4 ? ID_M4 : ID_M56;
    firstData   = strobes.pushM4 ? m4Entry : m56Entry;
    secondValid = strobes.pushM4 && strobes.pushM56;
    room        = DEPTH - int'(fill) + int'(popDo);
    acc0        = firstValid && (room >= 1);
    acc1        = secondValid && (room >= 2);
    dropped     = (firstValid && !acc0) || (secondValid && !acc1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fill      <= '0;
      qOverflow <= 1'b0;
      idMem     <= '0;
      dataMem   <= '0;
    end else begin
      if (acc0) begin
        idMem[wrPtr]   <= firstId;
        dataMem[wrPtr] <= firstData;
      end
      if (acc1) begin
        idMem[AW'(wrPtr + 1'b1)]   <= ID_M56;
        dataMem[AW'(wrPtr + 1'b1)] <= m56Entry;
      end
      wrPtr <= AW'(wrPtr + AW'(acc0) + AW'(acc1));
      rdPtr <= AW'(rdPtr + AW'(popDo));
      fill  <= CW'(fill - CW'(popDo) + CW'(acc0) + CW'(acc1));
      if (dropped) qOverflow <= 1'b1;
    end
  end

  assign qValid = (fill != '0);
  assign qRegId = idMem[rdPtr];
  assign qData  = dataMem[rdPtr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(fill) <= DEPTH); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    qOverflow |=> qOverflow); // R11
  AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !sfStrobe |=> ($stable(rxM4) && $stable(rxM56) && !$rose(fill != '0))); // R3
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && qValid && !strobes.pushM4 && !strobes.pushM56) |=> (fill == $past(fill) - 1'b1)); // R11

endmodule

// File: rtl/ovh_spare_validator.sv
module ovh_spare_validator
  import ovh_spare_pkg::*;
#(
  parameter int M4_W  = 3,
  parameter int M56_W = 4,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgQ,
  input  logic              sfStrobe,
  input  logic [M4_W-1:0]   m4In,
  input  logic [M56_W-1:0]  m56In,
  input  logic              crcMismatch,
  input  logic              febeIn,
  output logic [M4_W-1:0]   rxM4,
  output logic [M56_W-1:0]  rxM56,
  input  logic              popReq,
  output logic              qValid,
  output logic              qRegId,
  output logic [M56_W+1:0]  qData,
  output logic              qOverflow,
  output logic              nearErr,
  output logic              farErr
);

  ctrlStrobe_t strobes;
  logic [1:0]  mode;
  logic        m4Changed, m56Changed;

  ovh_spare_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgQ(cfgQ),
    .mode(mode), .sfStrobe(sfStrobe), .m4Changed(m4Changed), .m56Changed(m56Changed),
    .crcMismatch(crcMismatch), .febeIn(febeIn), .strobes(strobes),
    .nearErr(nearErr), .farErr(farErr));

  ovh_spare_dp #(.M4_W(M4_W), .M56_W(M56_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .sfStrobe(sfStrobe), .mode(mode), .m4In(m4In),
    .m56In(m56In), .crcMismatch(crcMismatch), .febeIn(febeIn), .strobes(strobes),
    .popReq(popReq), .rxM4(rxM4), .rxM56(rxM56), .m4Changed(m4Changed),
    .m56Changed(m56Changed), .qValid(qValid), .qRegId(qRegId), .qData(qData),
    .qOverflow(qOverflow));

  AST_M4_AHEAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pushM4 && strobes.pushM56 && !qValid) |=> (qValid && qRegId == ID_M4)); // R10

endmodule

// File: tb/ovh_spare_validator_bench.sv
module ovh_spare_validator_bench;

  localparam int M4_W = 3;
  localparam int M56_W = 4;
  localparam int DW = M56_W + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [7:0] cfgWdata = '0;
  logic [7:0] cfgQ;
  logic sfStrobe = 1'b0;
  logic [M4_W-1:0] m4In = '0;
  logic [M56_W-1:0] m56In = '0;
  logic crcMismatch = 1'b0;
  logic febeIn = 1'b1;
  logic [M4_W-1:0] rxM4;
  logic [M56_W-1:0] rxM56;
  logic popReq = 1'b0;
  logic qValid, qRegId, qOverflow, nearErr, farErr;
  logic [DW-1:0] qData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ovh_spare_validator u_ovh_spare_validator (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgQ(cfgQ),
    .sfStrobe(sfStrobe), .m4In(m4In), .m56In(m56In), .crcMismatch(crcMismatch),
    .febeIn(febeIn), .rxM4(rxM4), .rxM56(rxM56), .popReq(popReq), .qValid(qValid),
    .qRegId(qRegId), .qData(qData), .qOverflow(qOverflow), .nearErr(nearErr),
    .farErr(farErr));

  // m4, m56, expected rxM4, expected rxM56, entries queued, id of first entry (mode 10)
  localparam logic [16:0] VEC [6] = '{
    {3'b101, 4'b0011, 3'b000, 4'b0000, 2'd0, 1'b0},
    {3'b101, 4'b0011, 3'b101, 4'b0011, 2'd2, 1'b0},
    {3'b100, 4'b0011, 3'b101, 4'b0011, 2'd0, 1'b0},
    {3'b110, 4'b0111, 3'b100, 4'b0011, 2'd1, 1'b0},
    {3'b110, 4'b0111, 3'b110, 4'b0111, 2'd2, 1'b0},
    {3'b110, 4'b0111, 3'b110, 4'b0111, 2'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sfStrobe = 0; popReq = 0; cfgWe = 0;
    m4In = '0; m56In = '0; crcMismatch = 0; febeIn = 1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWe = 1; cfgWdata = v;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic strobe(input logic [M4_W-1:0] a, input logic [M56_W-1:0] b,
                        input logic crc, input logic fe);
    @(negedge clk);
    m4In = a; m56In = b; crcMismatch = crc; febeIn = fe; sfStrobe = 1;
    @(negedge clk);
    sfStrobe = 0;
  endtask

  task automatic popCheck(input string req, input logic id, input logic [DW-1:0] d);
    chk(req, qValid, 1);
    chk(req, qRegId, id);
    chk(req, qData, d);
    popReq = 1;
    @(negedge clk);
    popReq = 0;
  endtask

  task automatic drain();
    while (qValid) begin
      popReq = 1;
      @(negedge clk);
      popReq = 0;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    doReset();
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfgQ, 8'h1E);
    chk("R1 rxM4", rxM4, 0);
    chk("R1 rxM56", rxM56, 0);
    chk("R1 qValid", qValid, 0);
    chk("R1 qOverflow", qOverflow, 0);

    // R4 / R10 table walk in mode 10
    writeCfg(8'h10);
    for (int k = 0; k < 6; k++) begin
      logic [16:0] v;
      v = VEC[k];
      strobe(v[16:14], v[13:10], 0, 1);
      chk("R4 rxM4", rxM4, v[9:7]);
      chk("R4 rxM56", rxM56, v[6:3]);
      if (v[2:1] == 2'd2) begin
        popCheck("R10 first", 1'b0, DW'(v[9:7]));
        popCheck("R10 second", 1'b1, {2'b11, v[6:3]});
      end else if (v[2:1] == 2'd1) begin
        popCheck("R3 single", v[0], DW'(v[9:7]));
      end
      chk("R4 drained", qValid, 0);
    end

    // R2 transparent mode
    doReset();
    writeCfg(8'h00);
    for (int k = 0; k < 2; k++) begin
      strobe(3'b011, 4'b1010, 0, 1);
      chk("R2 rxM4", rxM4, 3'b011);
      chk("R2 rxM56", rxM56, 4'b1010);
      popCheck("R2 m4", 1'b0, 6'b000011);
      popCheck("R2 m56", 1'b1, 6'b111010);
      chk("R2 empty", qValid, 0);
    end

    // R3 on change
    writeCfg(8'h08);
    strobe(3'b011, 4'b1010, 0, 1);
    chk("R3 no change", qValid, 0);
    strobe(3'b011, 4'b1011, 0, 1);
    chk("R3 rxM56", rxM56, 4'b1011);
    popCheck("R3 m56", 1'b1, 6'b111011);
    chk("R3 one entry", qValid, 0);
    strobe(3'b001, 4'b1011, 0, 1);
    chk("R3 rxM4", rxM4, 3'b001);
    popCheck("R3 m4", 1'b0, 6'b000001);

    // R5 / R6 mode 11 (reset default)
    doReset();
    strobe(3'b001, 0, 0, 1);
    strobe(3'b001, 0, 0, 1);
    chk("R5 after two", rxM4, 3'b000);
    strobe(3'b001, 0, 0, 1);
    chk("R5 after three", rxM4, 3'b001);
    strobe(3'b011, 0, 0, 1);
    strobe(3'b011, 0, 0, 1);
    chk("R6 pending", rxM4, 3'b001);
    strobe(3'b111, 0, 0, 1);
    chk("R6 bit1 only", rxM4, 3'b011);
    popCheck("R5 entry", 1'b0, 6'b000001);
    popCheck("R6 entry", 1'b0, 6'b000011);
    chk("R6 empty", qValid, 0);

    // R7 CRC entry
    doReset();
    writeCfg(8'h98);
    strobe(0, 0, 1, 1);
    chk("R7 nearErr", nearErr, 1);
    popCheck("R7 entry", 1'b1, 6'b010000);

    // R8 far-end entry
    doReset();
    writeCfg(8'h38);
    strobe(0, 0, 0, 0);
    chk("R8 farErr", farErr, 1);
    popCheck("R8 entry", 1'b1, 6'b100000);

    // R9 disabled enables
    doReset();
    writeCfg(8'h18);
    strobe(0, 0, 1, 0);
    chk("R9 no entry", qValid, 0);
    chk("R9 nearErr", nearErr, 1);
    chk("R9 farErr", farErr, 1);
    @(negedge clk);
    chk("R9 nearErr end", nearErr, 0);
    chk("R9 farErr end", farErr, 0);

    // R11 overflow
    doReset();
    writeCfg(8'h00);
    strobe(3'd1, 0, 0, 1);
    strobe(3'd2, 0, 0, 1);
    chk("R11 no ovf yet", qOverflow, 0);
    strobe(3'd3, 0, 0, 1);
    chk("R11 ovf", qOverflow, 1);
    popCheck("R11 e0", 1'b0, 6'd1);
    popCheck("R11 e1", 1'b1, 6'b110000);
    popCheck("R11 e2", 1'b0, 6'd2);
    popCheck("R11 e3", 1'b1, 6'b110000);
    chk("R11 empty", qValid, 0);
    popReq = 1;
    @(negedge clk);
    popReq = 0;
    chk("R11 pop empty", qValid, 0);
    chk("R11 sticky", qOverflow, 1);
    drain();

    summary();
  end

endmodule